// File: doc/BRIEF.md
# Multiplicative Boost Frequency Engine

This block turns activity-monitor events into a frequency request for a memory clock governor. It keeps a boost value in kHz. A consecutive-above event scales the boost up by a percentage and adds a fixed step, saturating at the highest allowed frequency. A consecutive-below event scales it down and drops it to zero once it falls under half a step. When either limit is reached, the matching consecutive-watermark interrupt enable is turned off, so the monitor stops reporting events in a direction where nothing more can change.

Every event, and every average-sample strobe, also refreshes a set of derived values from the current average activity count. These are a frequency target (average per sampling period, scaled by the inverse of the up-threshold percentage, plus the boost), the average watermarks placed a band above and below the average, and the raw watermarks taken as threshold percentages of the cycles in one period at the current frequency. All results are registered one cycle after the strobe and are marked by a one-cycle done pulse.

Top module: `boost_freq_engine`

## Requirements
- R1: An up event sets the boost to floor(boost × up_coeff / 100) + STEP, where STEP defaults to 16000.
- R2: When the up-event result is greater than or equal to max_freq, the boost becomes max_freq and above_en becomes 0. Otherwise above_en becomes 1.
- R3: A down event without an up event sets the boost to floor(boost × dn_coeff / 100). A result that is at least STEP/2 and above max_freq is limited to max_freq.
- R4: When the down-event result is below STEP/2, the boost becomes 0 and below_en becomes 0. Otherwise below_en becomes 1.
- R5: An up event sets below_en to 1, and a down event sets above_en to 1. Each event re-enables the opposite direction.
- R6: When up and down events arrive in the same cycle, only the up event acts.
- R7: On any strobe, target becomes floor(floor(floor(avg / PERIOD) × S) / 100) + boost. S is floor(10000 / up_thresh), or 0 when up_thresh is 0, and the boost used is the value after that cycle's event. PERIOD defaults to 12.
- R8: On any strobe, the upper average watermark becomes avg + band_freq × PERIOD. The lower one becomes avg − band_freq × PERIOD, or 0 when avg is not above band_freq × PERIOD.
- R9: On any strobe, the upper and lower raw watermarks become floor(cur_freq × PERIOD × up_thresh / 100) and floor(cur_freq × PERIOD × dn_thresh / 100).
- R10: done is 1 exactly in the cycle after an up, down or sample strobe. Without an event, the boost and both enables keep their values. Without any strobe, target and all watermarks keep their values.
- R11: After reset, the boost, the target and the watermarks are 0, both enables are 1 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| up_evt_i | input | 1 | Consecutive-above event pulse |
| dn_evt_i | input | 1 | Consecutive-below event pulse |
| smp_vld_i | input | 1 | New average sample, refreshes target and watermarks |
| avg_count_i | input | COUNT_W | Average activity count |
| cur_freq_i | input | FREQ_W | Current clock frequency, kHz |
| max_freq_i | input | FREQ_W | Highest allowed frequency, kHz |
| band_freq_i | input | FREQ_W | Average band width, kHz |
| up_coeff_i | input | COEF_W | Up scaling percentage |
| dn_coeff_i | input | COEF_W | Down scaling percentage |
| up_thresh_i | input | COEF_W | Upper threshold percentage |
| dn_thresh_i | input | COEF_W | Lower threshold percentage |
| boost_o | output | FREQ_W | Current boost, kHz |
| target_o | output | TGT_W | Frequency target, kHz |
| avg_hi_wm_o | output | TGT_W | Upper average watermark |
| avg_lo_wm_o | output | TGT_W | Lower average watermark |
| raw_hi_wm_o | output | TGT_W | Upper raw watermark |
| raw_lo_wm_o | output | TGT_W | Lower raw watermark |
| above_en_o | output | 1 | Consecutive-above interrupt enable |
| below_en_o | output | 1 | Consecutive-below interrupt enable |
| done_o | output | 1 | Results updated in this cycle |

## Verification
Runs of up events from zero under two coefficient sets show whether the geometric growth with the added step reaches the ceiling on the right event. A further up event at the ceiling shows that the above enable stays off. A chain of down events then halves the boost down to the snap point, and one extra down event at zero separates the snap from plain truncation. Up and down pulses in the same cycle, idle cycles, an up threshold of zero, and averages below and above the band cover priority, hold and the watermark floor. A stretch of random events and averages then drives every path against the behavioural model.

// File: rtl/boost_pkg.sv
package boost_pkg;

    localparam int unsigned PCT_DIV     = 100;
    localparam int unsigned SUSTAIN_NUM = 10000;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_UP   = 2'd1,
        EV_DOWN = 2'd2
    } evt_e;

endpackage

// File: rtl/boost_step_unit.sv
module boost_step_unit
    import boost_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int COEF_W = 10,
    parameter int STEP   = 16000
) (
    input  evt_e              evt_i,
    input  logic [FREQ_W-1:0] boost_i,
    input  logic [FREQ_W-1:0] max_freq_i,
    input  logic [COEF_W-1:0] up_coeff_i,
    input  logic [COEF_W-1:0] dn_coeff_i,
    output logic [FREQ_W-1:0] boost_o,
    output logic              above_ok_o,
    output logic              below_ok_o
);

    localparam int PW = FREQ_W + COEF_W + 1;
    localparam logic [PW-1:0] HUNDRED   = PW'(PCT_DIV);
    localparam logic [PW-1:0] STEP_W    = PW'(STEP);
    localparam logic [PW-1:0] HALF_STEP = PW'(STEP / 2);

    logic [PW-1:0] up_q, dn_q, max_w;

    always_comb begin
        max_w = PW'(max_freq_i);
        up_q  = (PW'(boost_i) * PW'(up_coeff_i)) / HUNDRED + STEP_W;
        dn_q  = (PW'(boost_i) * PW'(dn_coeff_i)) / HUNDRED;

        boost_o    = boost_i;
        above_ok_o = 1'b1;
        below_ok_o = 1'b1;
        unique case (evt_i)
            EV_UP: begin
                if (up_q >= max_w) begin
                    boost_o    = max_freq_i;
                    above_ok_o = 1'b0;
                end else begin
                    boost_o = FREQ_W'(up_q);
                end
            end
            EV_DOWN: begin
                if (dn_q < HALF_STEP) begin
                    boost_o    = '0;
                    below_ok_o = 1'b0;
                end else if (dn_q > max_w) begin
                    boost_o = max_freq_i;
                end else begin
                    boost_o = FREQ_W'(dn_q);
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/target_calc.sv
module target_calc
    import boost_pkg::*;
#(
    parameter int COUNT_W = 32,
    parameter int FREQ_W  = 32,
    parameter int COEF_W  = 10,
    parameter int PERIOD  = 12,
    parameter int TGT_W   = 40
) (
    input  logic [COUNT_W-1:0] avg_i,
    input  logic [COEF_W-1:0]  up_thresh_i,
    input  logic [FREQ_W-1:0]  boost_i,
    output logic [TGT_W-1:0]   target_o
);

    localparam int DW = (COEF_W > 14) ? COEF_W : 14;
    localparam int PW = COUNT_W + DW;

    logic [COUNT_W-1:0] per_avg;
    logic [DW-1:0]      sustain;
    logic [PW-1:0]      scaled;

    always_comb begin
        per_avg = avg_i / COUNT_W'(PERIOD);
        if (up_thresh_i == '0) begin
            sustain = '0;
        end else begin
            sustain = DW'(SUSTAIN_NUM) / DW'(up_thresh_i);
        end
        scaled   = (PW'(per_avg) * PW'(sustain)) / PW'(PCT_DIV);
        target_o = TGT_W'(scaled) + TGT_W'(boost_i);
    end

endmodule

// File: rtl/wmark_calc.sv
module wmark_calc
    import boost_pkg::*;
#(
    parameter int COUNT_W = 32,
    parameter int FREQ_W  = 32,
    parameter int COEF_W  = 10,
    parameter int PERIOD  = 12,
    parameter int TGT_W   = 40
) (
    input  logic [COUNT_W-1:0] avg_i,
    input  logic [FREQ_W-1:0]  band_freq_i,
    input  logic [FREQ_W-1:0]  cur_freq_i,
    input  logic [COEF_W-1:0]  up_thresh_i,
    input  logic [COEF_W-1:0]  dn_thresh_i,
    output logic [TGT_W-1:0]   avg_hi_o,
    output logic [TGT_W-1:0]   avg_lo_o,
    output logic [TGT_W-1:0]   raw_hi_o,
    output logic [TGT_W-1:0]   raw_lo_o
);

    localparam int PER_W = $clog2(PERIOD + 1);
    localparam int RW    = FREQ_W + PER_W + COEF_W;

    logic [TGT_W-1:0]  band_w, avg_w;
    logic [COEF_W-1:0] thr   [2];
    logic [TGT_W-1:0]  raw_w [2];

    always_comb begin
        band_w   = TGT_W'(band_freq_i) * TGT_W'(PERIOD);
        avg_w    = TGT_W'(avg_i);
        avg_hi_o = avg_w + band_w;
        avg_lo_o = (avg_w > band_w) ? (avg_w - band_w) : '0;
        thr[0]   = up_thresh_i;
        thr[1]   = dn_thresh_i;
    end

    for (genvar g = 0; g < 2; g++) begin : g_raw
        logic [RW-1:0] cyc;
        always_comb begin
            cyc      = RW'(cur_freq_i) * RW'(PERIOD);
            raw_w[g] = TGT_W'((cyc * RW'(thr[g])) / RW'(PCT_DIV));
        end
    end

    assign raw_hi_o = raw_w[0];
    assign raw_lo_o = raw_w[1];

endmodule

// File: rtl/boost_freq_engine.sv
module boost_freq_engine
    import boost_pkg::*;
#(
    parameter int FREQ_W  = 32,
    parameter int COUNT_W = 32,
    parameter int COEF_W  = 10,
    parameter int STEP    = 16000,
    parameter int PERIOD  = 12,
    parameter int TGT_W   = ((COUNT_W > FREQ_W) ? COUNT_W : FREQ_W) + 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               up_evt_i,
    input  logic               dn_evt_i,
    input  logic               smp_vld_i,
    input  logic [COUNT_W-1:0] avg_count_i,
    input  logic [FREQ_W-1:0]  cur_freq_i,
    input  logic [FREQ_W-1:0]  max_freq_i,
    input  logic [FREQ_W-1:0]  band_freq_i,
    input  logic [COEF_W-1:0]  up_coeff_i,
    input  logic [COEF_W-1:0]  dn_coeff_i,
    input  logic [COEF_W-1:0]  up_thresh_i,
    input  logic [COEF_W-1:0]  dn_thresh_i,
    output logic [FREQ_W-1:0]  boost_o,
    output logic [TGT_W-1:0]   target_o,
    output logic [TGT_W-1:0]   avg_hi_wm_o,
    output logic [TGT_W-1:0]   avg_lo_wm_o,
    output logic [TGT_W-1:0]   raw_hi_wm_o,
    output logic [TGT_W-1:0]   raw_lo_wm_o,
    output logic               above_en_o,
    output logic               below_en_o,
    output logic               done_o
);

    typedef struct packed {
        logic [FREQ_W-1:0] boost;
        logic              above_en;
        logic              below_en;
        logic [TGT_W-1:0]  target;
        logic [TGT_W-1:0]  avg_hi;
        logic [TGT_W-1:0]  avg_lo;
        logic [TGT_W-1:0]  raw_hi;
        logic [TGT_W-1:0]  raw_lo;
        logic              done;
    } state_t;

    localparam state_t RST_STATE = '{
        boost: '0, above_en: 1'b1, below_en: 1'b1, target: '0,
        avg_hi: '0, avg_lo: '0, raw_hi: '0, raw_lo: '0, done: 1'b0
    };

    state_t st_d, st_q;
    evt_e   evt;
    logic   strobe;
    logic [FREQ_W-1:0] boost_nxt;
    logic              above_ok, below_ok;
    logic [TGT_W-1:0]  tgt_nxt, ahi_nxt, alo_nxt, rhi_nxt, rlo_nxt;

    // Up wins over down when both arrive together
    always_comb begin
        if (up_evt_i)      evt = EV_UP;
        else if (dn_evt_i) evt = EV_DOWN;
        else               evt = EV_NONE;
        strobe = up_evt_i | dn_evt_i | smp_vld_i;
    end

    boost_step_unit #(
        .FREQ_W (FREQ_W),
        .COEF_W (COEF_W),
        .STEP   (STEP)
    ) i_step (
        .evt_i      (evt),
        .boost_i    (st_q.boost),
        .max_freq_i (max_freq_i),
        .up_coeff_i (up_coeff_i),
        .dn_coeff_i (dn_coeff_i),
        .boost_o    (boost_nxt),
        .above_ok_o (above_ok),
        .below_ok_o (below_ok)
    );

    target_calc #(
        .COUNT_W (COUNT_W),
        .FREQ_W  (FREQ_W),
        .COEF_W  (COEF_W),
        .PERIOD  (PERIOD),
        .TGT_W   (TGT_W)
    ) i_target (
        .avg_i       (avg_count_i),
        .up_thresh_i (up_thresh_i),
        .boost_i     (boost_nxt),
        .target_o    (tgt_nxt)
    );

    wmark_calc #(
        .COUNT_W (COUNT_W),
        .FREQ_W  (FREQ_W),
        .COEF_W  (COEF_W),
        .PERIOD  (PERIOD),
        .TGT_W   (TGT_W)
    ) i_wmark (
        .avg_i       (avg_count_i),
        .band_freq_i (band_freq_i),
        .cur_freq_i  (cur_freq_i),
        .up_thresh_i (up_thresh_i),
        .dn_thresh_i (dn_thresh_i),
        .avg_hi_o    (ahi_nxt),
        .avg_lo_o    (alo_nxt),
        .raw_hi_o    (rhi_nxt),
        .raw_lo_o    (rlo_nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = strobe;
        if (evt != EV_NONE) begin
            st_d.boost    = boost_nxt;
            st_d.above_en = above_ok;
            st_d.below_en = below_ok;
        end
        if (strobe) begin
            st_d.target = tgt_nxt;
            st_d.avg_hi = ahi_nxt;
            st_d.avg_lo = alo_nxt;
            st_d.raw_hi = rhi_nxt;
            st_d.raw_lo = rlo_nxt;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= RST_STATE;
        else         st_q <= st_d;
    end

    assign boost_o     = st_q.boost;
    assign target_o    = st_q.target;
    assign avg_hi_wm_o = st_q.avg_hi;
    assign avg_lo_wm_o = st_q.avg_lo;
    assign raw_hi_wm_o = st_q.raw_hi;
    assign raw_lo_wm_o = st_q.raw_lo;
    assign above_en_o  = st_q.above_en;
    assign below_en_o  = st_q.below_en;
    assign done_o      = st_q.done;

    // Boost never passes the ceiling after an up event
    assert_boost_ceiling_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        up_evt_i |=> boost_o <= $past(max_freq_i));

    // Above enable is off exactly when the up event saturated
    assert_clamp_disables_above_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        up_evt_i |=> (above_en_o == (boost_o != $past(max_freq_i))));

    // Below enable is off exactly when the down event snapped to zero
    assert_snap_disables_below_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dn_evt_i && !up_evt_i && max_freq_i >= FREQ_W'(STEP / 2))
        |=> (below_en_o == (boost_o != '0)));

    assert_up_reenables_below_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        up_evt_i |=> below_en_o);

    assert_down_reenables_above_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dn_evt_i && !up_evt_i) |=> above_en_o);

    assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (up_evt_i || dn_evt_i || smp_vld_i) |=> done_o);

    assert_no_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(up_evt_i || dn_evt_i || smp_vld_i) |=> !done_o);

    assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(up_evt_i || dn_evt_i) |=> ($stable(boost_o) && $stable(above_en_o) && $stable(below_en_o)));

    assert_wm_order_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> avg_lo_wm_o <= avg_hi_wm_o);

endmodule

// File: tb/test_boost_freq_engine.sv
module test_boost_freq_engine;

    localparam int FREQ_W = 32, COUNT_W = 32, COEF_W = 10, TGT_W = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic up = 0, dn = 0, smp = 0;
    logic [COUNT_W-1:0] avg = '0;
    logic [FREQ_W-1:0]  curf = '0, maxf = '0, bandf = '0;
    logic [COEF_W-1:0]  upc = '0, dnc = '0, uth = '0, dth = '0;

    logic [FREQ_W-1:0] boost;
    logic [TGT_W-1:0]  target, ahi, alo, rhi, rlo;
    logic              ab, be, done;

    boost_freq_engine i_boost_freq_engine (
        .clk_i(clk), .rst_ni(rst_n), .up_evt_i(up), .dn_evt_i(dn), .smp_vld_i(smp),
        .avg_count_i(avg), .cur_freq_i(curf), .max_freq_i(maxf), .band_freq_i(bandf),
        .up_coeff_i(upc), .dn_coeff_i(dnc), .up_thresh_i(uth), .dn_thresh_i(dth),
        .boost_o(boost), .target_o(target), .avg_hi_wm_o(ahi), .avg_lo_wm_o(alo),
        .raw_hi_wm_o(rhi), .raw_lo_wm_o(rlo), .above_en_o(ab), .below_en_o(be),
        .done_o(done)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    longint unsigned m_boost, m_tgt, m_ahi, m_alo, m_rhi, m_rlo;
    bit m_ab, m_be, m_done;
    string tag_b, tag_a, tag_w;

    task automatic chk(string tag, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, evaluated right after each rising edge
    task automatic model_update();
        longint unsigned b, sus, band;
        if (!rst_n) begin
            m_boost = 0; m_ab = 1; m_be = 1; m_done = 0;
            m_tgt = 0; m_ahi = 0; m_alo = 0; m_rhi = 0; m_rlo = 0;
            tag_b = "R11"; tag_a = "R11"; tag_w = "R11";
            return;
        end
        m_done = up | dn | smp;
        tag_w = "R10"; tag_b = "R10"; tag_a = "R10";
        if (up) begin
            tag_b = dn ? "R6" : "R1"; tag_a = "R2";
            b = m_boost * upc / 100 + 16000;
            m_be = 1;
            if (b >= maxf) begin b = maxf; m_ab = 0; end else m_ab = 1;
            m_boost = b;
        end else if (dn) begin
            tag_b = "R3"; tag_a = "R4";
            b = m_boost * dnc / 100;
            m_ab = 1;
            if (b < 8000) begin b = 0; m_be = 0; end
            else begin m_be = 1; if (b > maxf) b = maxf; end
            m_boost = b;
        end
        if (m_done) begin
            tag_w = "R8";
            sus = (uth == 0) ? 0 : 10000 / uth;
            m_tgt = ((avg / 12) * sus) / 100 + m_boost;
            band = bandf * 12;
            m_ahi = avg + band;
            m_alo = (avg > band) ? avg - band : 0;
            m_rhi = curf * 12 * uth / 100;
            m_rlo = curf * 12 * dth / 100;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        #2;
        chk(tag_b, boost, m_boost);
        chk(tag_a, ab, m_ab);
        chk((tag_a == "R2") ? "R5" : tag_a, be, m_be);
        chk((tag_w == "R8") ? "R7" : tag_w, target, m_tgt);
        chk(tag_w, ahi, m_ahi);
        chk(tag_w, alo, m_alo);
        chk((tag_w == "R8") ? "R9" : tag_w, rhi, m_rhi);
        chk((tag_w == "R8") ? "R9" : tag_w, rlo, m_rlo);
        chk((tag_w == "R11") ? "R11" : "R10", done, m_done);
    endtask

    task automatic ev(bit u, bit d, bit s);
        up = u; dn = d; smp = s;
        step();
        up = 0; dn = 0; smp = 0;
    endtask

    initial begin
        #2;
        repeat (3) step();                     // R11 reset state
        rst_n = 1'b1;
        maxf = 300000; curf = 300000; bandf = 1800;
        upc = 200; dnc = 50; uth = 60; dth = 40;
        avg = 32'd3600000;
        ev(0, 0, 0);                            // R10 idle hold
        ev(0, 0, 1);                            // R7 R8 R9 sample refresh
        repeat (6) ev(1, 0, 0);                 // R1 growth, R2 clamp at 5th
        ev(0, 0, 0);
        repeat (8) ev(0, 1, 0);                 // R3 decay, R4 snap and stay at zero
        ev(1, 1, 0);                            // R6 up wins
        upc = 800; dnc = 90; uth = 27; dth = 10;
        maxf = 2000000;
        repeat (4) ev(1, 0, 0);
        repeat (10) ev(0, 1, 0);
        avg = 32'd500; bandf = 5000; ev(0, 0, 1);   // R8 lower watermark floor
        avg = 32'hFFFF_FFFF; ev(0, 0, 1);           // wide average
        uth = 0; ev(0, 0, 1);                       // R7 zero threshold
        ev(0, 0, 0);
        maxf = 300000; uth = 60; dnc = 150;
        ev(1, 0, 0); ev(1, 0, 0); ev(0, 1, 0);      // R3 down limit at max
        for (int i = 0; i < 200; i++) begin
            avg  = $urandom;
            upc  = COEF_W'($urandom_range(100, 900));
            dnc  = COEF_W'($urandom_range(10, 99));
            uth  = COEF_W'($urandom_range(0, 100));
            dth  = COEF_W'($urandom_range(0, 100));
            curf = $urandom_range(1000, 2000000);
            maxf = $urandom_range(10000, 2000000);
            bandf = $urandom_range(0, 20000);
            ev(($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0);
        end
        rst_n = 1'b0; step(); rst_n = 1'b1;     // R11 reset after activity
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule